// File: doc/BRIEF.md
# I2C Stuck-Data Recovery Sequencer

When a target device has been cut off in the middle of a byte, it can keep SDA low forever, and no controller can then start a transfer. This block frees such a bus in hardware. On a one-cycle recover command it first looks at both lines. If SCL and SDA are already high, the bus is idle and the block reports success at once. If not, it drives SCL open-drain pulses one at a time. After each pulse it samples SDA while SCL is released. It stops as soon as SDA reads high, or after a fixed number of pulses.

A release is followed by a generated STOP condition. A STOP puts every target back in its idle state. Only then does the block raise a one-cycle completion strobe together with a success flag. Timing comes from a half-bit tick supplied by the bus clock divider. Every phase of the sequence lasts from one tick to the next.

States:
- `ST_IDLE`: waiting for a command.
- `ST_PULSE_LO`: SCL pulled low.
- `ST_PULSE_HI`: SCL released and SDA sampled.
- `ST_STOP_PRE`: SCL low, SDA released.
- `ST_STOP_HOLD`: SCL low, SDA low.
- `ST_STOP_RISE`: SCL released, SDA low.
- `ST_DONE_OK`: completion with success.
- `ST_DONE_FAIL`: completion without success.

Transitions:
- IDLE→DONE_OK: command while the bus is idle.
- IDLE→PULSE_LO: command while the bus is not idle.
- PULSE_LO→PULSE_HI: on a tick.
- PULSE_HI→STOP_PRE: on a tick with SDA high.
- PULSE_HI→PULSE_LO: on a tick with SDA low and pulses remaining.
- PULSE_HI→DONE_FAIL: on a tick with SDA low on the last pulse.
- STOP_PRE→STOP_HOLD→STOP_RISE→DONE_OK: one step per tick.
- DONE_OK or DONE_FAIL→IDLE: unconditionally, after one cycle.

Top module: `bus_unhang_seq`

## Requirements
- R1: During and right after reset, all outputs are low. Both lines are released, `done`, `ok` and `busy` are low, and the block is idle.
- R2: A command sampled in idle with `scl_in` and `sda_in` both high makes `done` and `ok` high in the next cycle. It drives no SCL pulse and `busy` stays low.
- R3: A command sampled in idle with either line low makes `busy` high in the next cycle and pulls SCL low (`scl_pull`=1). SCL stays low until the next tick, then is released until the tick after that.
- R4: At the tick that ends a released SCL half, SDA is sampled. SDA high starts the STOP sequence. SDA low with fewer than MAX_PULSES (8) pulses given starts another pulse.
- R5: If SDA is still low at the sample of pulse MAX_PULSES, the next cycle shows `done`=1 with `ok`=0. No STOP follows. Exactly MAX_PULSES SCL pulses are given.
- R6: The STOP sequence runs for one tick interval per step:
  - SCL low with SDA released,
  - then SDA low with SCL low,
  - then SCL released with SDA low,
  - then both released together with `done`=1 and `ok`=1.
- R7: `done` is high for exactly one cycle per command. `ok` is never high without `done`. `busy` is low in idle and in the completion cycle.
- R8: A command that arrives while `busy` is high is ignored. The sequence in progress continues unchanged.
- R9: SDA is pulled low only inside the STOP sequence, and only while SCL was pulled low first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recover_req | input | 1 | One-cycle recover command |
| tick | input | 1 | One-cycle strobe every half bit period |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_pull | output | 1 | Open-drain enable: 1 pulls SCL low |
| sda_pull | output | 1 | Open-drain enable: 1 pulls SDA low |
| done | output | 1 | One-cycle completion strobe |
| ok | output | 1 | Success, valid with `done` |
| busy | output | 1 | Sequence in progress |

## Verification
Every output is decoded from the state register, so each result is due one clock edge after the input that causes it:
- drive changes appear after the edge at which a tick is sampled;
- the completion strobe appears after the edge that samples the last tick, or after the command for an idle bus.

The bench model advances on the same edge from the same inputs. Outputs are compared at the following falling edge. This puts every comparison exactly one register stage after its cause.

Each scenario also counts SCL rising edges seen on the modelled wired line and checks the final outcome flag. This confirms the number of pulses and whether a STOP was added, whatever the tick phase at the moment the command arrived.

// File: rtl/unhang_pkg.sv
package unhang_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE_LO,
        ST_PULSE_HI,
        ST_STOP_PRE,
        ST_STOP_HOLD,
        ST_STOP_RISE,
        ST_DONE_OK,
        ST_DONE_FAIL
    } seq_state_e;
endpackage

// File: rtl/unhang_pulse_ctr.sv
module unhang_pulse_ctr #(
    parameter int MAX_PULSES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last
);
    localparam int CW = (MAX_PULSES > 1) ? $clog2(MAX_PULSES) : 1;
    localparam logic [CW-1:0] LAST_VAL = CW'(MAX_PULSES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == LAST_VAL);
endmodule

// File: rtl/bus_unhang_seq.sv
module bus_unhang_seq
    import unhang_pkg::*;
#(
    parameter int MAX_PULSES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic recover_req,
    input  logic tick,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_pull,
    output logic sda_pull,
    output logic done,
    output logic ok,
    output logic busy
);
    seq_state_e state_q, state_d;
    logic       last_pulse;
    logic       ctr_clear;
    logic       ctr_step;

    assign ctr_clear = (state_q == ST_IDLE);
    assign ctr_step  = (state_q == ST_PULSE_HI) && tick && !sda_in && !last_pulse;

    unhang_pulse_ctr #(.MAX_PULSES(MAX_PULSES)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (ctr_clear),
        .step  (ctr_step),
        .last  (last_pulse)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (recover_req) begin
                    state_d = (scl_in && sda_in) ? ST_DONE_OK : ST_PULSE_LO;
                end
            end
            ST_PULSE_LO: begin
                if (tick) state_d = ST_PULSE_HI;
            end
            ST_PULSE_HI: begin
                if (tick) begin
                    if (sda_in)          state_d = ST_STOP_PRE;
                    else if (last_pulse) state_d = ST_DONE_FAIL;
                    else                 state_d = ST_PULSE_LO;
                end
            end
            ST_STOP_PRE: begin
                if (tick) state_d = ST_STOP_HOLD;
            end
            ST_STOP_HOLD: begin
                if (tick) state_d = ST_STOP_RISE;
            end
            ST_STOP_RISE: begin
                if (tick) state_d = ST_DONE_OK;
            end
            ST_DONE_OK:   state_d = ST_IDLE;
            ST_DONE_FAIL: state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        scl_pull = 1'b0;
        sda_pull = 1'b0;
        done     = 1'b0;
        ok       = 1'b0;
        busy     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PULSE_LO: begin
                scl_pull = 1'b1;
                busy     = 1'b1;
            end
            ST_PULSE_HI: begin
                busy = 1'b1;
            end
            ST_STOP_PRE: begin
                scl_pull = 1'b1;
                busy     = 1'b1;
            end
            ST_STOP_HOLD: begin
                scl_pull = 1'b1;
                sda_pull = 1'b1;
                busy     = 1'b1;
            end
            ST_STOP_RISE: begin
                sda_pull = 1'b1;
                busy     = 1'b1;
            end
            ST_DONE_OK: begin
                done = 1'b1;
                ok   = 1'b1;
            end
            ST_DONE_FAIL: begin
                done = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bus_unhang_seq_chk.sv
module bus_unhang_seq_chk #(
    parameter int MAX_PULSES = 8
) (
    input logic clk,
    input logic rst_n,
    input logic recover_req,
    input logic scl_in,
    input logic sda_in,
    input logic scl_pull,
    input logic sda_pull,
    input logic done,
    input logic ok,
    input logic busy
);
    logic        prev_scl_pull;
    logic [31:0] n_pulls;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_scl_pull <= 1'b0;
            n_pulls       <= '0;
        end else begin
            prev_scl_pull <= scl_pull;
            if (!busy) n_pulls <= '0;
            else if (scl_pull && !prev_scl_pull) n_pulls <= n_pulls + 1;
        end
    end

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_ok_only_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> done);
    p_not_busy_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    p_start_on_stuck_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && recover_req && !(scl_in && sda_in)) |=> (busy && scl_pull));
    p_idle_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && recover_req && scl_in && sda_in) |=> (done && ok));
    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && recover_req) |=> (busy || done));
    p_sda_fall_under_low_scl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> (scl_pull && $past(scl_pull)));
    p_sda_rise_scl_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull) |-> (!scl_pull && done && ok));
    p_quiet_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_pull && !sda_pull));
    p_pulse_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (n_pulls <= MAX_PULSES + 1));
endmodule

bind bus_unhang_seq bus_unhang_seq_chk #(.MAX_PULSES(MAX_PULSES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .recover_req (recover_req),
    .scl_in      (scl_in),
    .sda_in      (sda_in),
    .scl_pull    (scl_pull),
    .sda_pull    (sda_pull),
    .done        (done),
    .ok          (ok),
    .busy        (busy)
);

// File: tb/test_bus_unhang_seq.sv
module test_bus_unhang_seq;
    localparam int MAXP = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic recover_req = 1'b0;
    logic tick = 1'b0;
    logic hold = 1'b0;
    logic scl_in, sda_in;
    logic scl_pull, sda_pull, done, ok, busy;

    always #5 clk = ~clk;

    assign scl_in = ~scl_pull;
    assign sda_in = ~sda_pull & ~hold;

    bus_unhang_seq #(.MAX_PULSES(MAXP)) i_bus_unhang_seq (
        .clk(clk), .rst_n(rst_n), .recover_req(recover_req), .tick(tick),
        .scl_in(scl_in), .sda_in(sda_in), .scl_pull(scl_pull),
        .sda_pull(sda_pull), .done(done), .ok(ok), .busy(busy)
    );

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    int hold_k  = 0;
    int rises   = 0;
    int tick_div = 0;
    logic prev_scl = 1'b1;
    bit finished = 1'b0;

    // behavioural model: phase 0 idle, 1 low half, 2 high half, 3..5 stop steps, 6 done ok, 7 done fail
    int m_phase  = 0;
    int m_pulses = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_pulses = 0;
        end else begin
            if (m_phase == 0) begin
                if (recover_req) begin
                    m_pulses = 0;
                    m_phase = (scl_in && sda_in) ? 6 : 1;
                end
            end else if (m_phase == 1) begin
                if (tick) m_phase = 2;
            end else if (m_phase == 2) begin
                if (tick) begin
                    m_pulses = m_pulses + 1;
                    if (sda_in) m_phase = 3;
                    else if (m_pulses == MAXP) m_phase = 7;
                    else m_phase = 1;
                end
            end else if (m_phase >= 3 && m_phase <= 5) begin
                if (tick) m_phase = m_phase + 1;
            end else begin
                m_phase = 0;
            end
        end
    end

    task automatic cmp(input string req, input string name, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", req, name, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            cmp("R3 R4", "scl_pull", scl_pull, (m_phase == 1 || m_phase == 3 || m_phase == 4));
            cmp("R6 R9", "sda_pull", sda_pull, (m_phase == 4 || m_phase == 5));
            cmp("R7", "done", done, (m_phase == 6 || m_phase == 7));
            cmp("R5", "ok", ok, (m_phase == 6));
            cmp("R8", "busy", busy, (m_phase >= 1 && m_phase <= 5));
        end
        if (scl_in && !prev_scl) rises++;
        prev_scl = scl_in;
        hold = (rises < hold_k);
        tick_div = (tick_div + 1) % 4;
        tick = (tick_div == 3);
    end

    task automatic scenario(input int k, input bit exp_ok, input int exp_rises,
                            input bit poke_busy, input string req);
        bit seen_ok;
        hold_k = k;
        rises = 0;
        @(negedge clk);
        hold = (rises < hold_k);
        recover_req = 1'b1;
        @(negedge clk);
        recover_req = 1'b0;
        seen_ok = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (poke_busy && i == 6) recover_req = 1'b1;
            if (poke_busy && i == 7) recover_req = 1'b0;
            if (done) begin
                seen_ok = ok;
                break;
            end
            @(negedge clk);
        end
        vectors++;
        if (seen_ok !== exp_ok) begin
            errors++;
            $display("FAIL %s outcome actual=%0b expected=%0b", req, seen_ok, exp_ok);
        end
        repeat (3) @(negedge clk);
        vectors++;
        if (rises != exp_rises) begin
            errors++;
            $display("FAIL %s scl rises actual=%0d expected=%0d", req, rises, exp_rises);
        end
        hold_k = 0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        vectors++;
        if ({scl_pull, sda_pull, done, ok, busy} !== 5'b0) begin
            errors++;
            $display("FAIL R1 outputs actual=%b expected=00000", {scl_pull, sda_pull, done, ok, busy});
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        vectors++;
        if ({scl_pull, sda_pull, done, ok, busy} !== 5'b0) begin
            errors++;
            $display("FAIL R1 after reset actual=%b expected=00000", {scl_pull, sda_pull, done, ok, busy});
        end
        scenario(0, 1'b1, 0, 1'b0, "R2");
        scenario(1, 1'b1, 2, 1'b0, "R4 R6");
        scenario(3, 1'b1, 4, 1'b0, "R4 R6");
        scenario(MAXP, 1'b1, MAXP + 1, 1'b0, "R4 R6");
        scenario(1000, 1'b0, MAXP, 1'b0, "R5");
        scenario(5, 1'b1, 6, 1'b1, "R8");
        scenario(1000, 1'b0, MAXP, 1'b1, "R5 R8");
        scenario(2, 1'b1, 3, 1'b0, "R3 R6");
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            vectors++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule